// File: doc/BRIEF.md
# Weighted and Static-Priority Queue Scheduler

This block chooses which of up to sixteen output queues bound to a single port may send next. Each queue holds a four-bit priority code, a membership bit and a tail bit, written through a small configuration port. Codes 0 to 8 are weights. Each weight is expanded into an 8-bit round mask with evenly spaced bits, so a queue's share of grants grows in proportion to its code. Code 9 marks a queue as strict priority. Those queues sit in a group at the bottom of the port and always win over weighted queues.

Arbitration runs over an eight-round cycle. A ready strict-priority queue is granted first, and the lowest index wins among them. Otherwise the scheduler looks at the current round and treats a weighted queue as eligible when bit r of its mask is set. It rotates among eligible queues, starting after the queue it last granted in that round. Rounds with no eligible queue are skipped within the same cycle.

The grant leaves on a valid/ready stream. `gnt_valid` is raised whenever a queue can be granted. If `gnt_ready` is low, the scheduler holds its round and rotation state, so `gnt_qid` stays the same as long as `q_ready` does not change. The state advances only on a cycle where both are high. The configuration is checked all the time and the result is reported on plain status pins.

Top module: `wrr_qsched`

## Requirements
- R1: Codes 0..8 map to round masks 0x00, 0x01, 0x11, 0x49, 0x55, 0x57, 0x77, 0x7F, 0xFF. Bit r of the mask enables the queue in round r. Code 0 is never granted.
- R2: Code 9 marks a strict-priority queue with mask 0xFF. While any such member is ready, the grant goes to the lowest-indexed ready one, ahead of all weighted queues.
- R3: The round counter starts at 0 after reset. It moves to the round after the one just served on every accepted weighted grant. In round r only weighted queues with mask bit r set may be granted.
- R4: If the current round has no eligible ready queue, the first later round (wrapping) that has one is served in the same cycle. With no eligible ready queue in any round, `gnt_valid` stays low.
- R5: Within a round, the search starts at the queue after the last one granted in that round, wrapping around. Each round's pointer starts so that the first search begins at queue 0.
- R6: Codes 10..15 on a member raise `err_code`, and that queue is treated as weighted with mask 0xFF.
- R7: `err_static` is high when the strict-priority members do not form one unbroken run that starts at queue 0.
- R8: `has_static` is high when any member has code 9. `static_last_qid` gives the highest such queue index, or 0 when there is none.
- R9: A queue is part of the port only if its membership bit is set and no lower-indexed queue has its tail bit set. Other queues are never granted.
- R10: State changes only when `gnt_valid` and `gnt_ready` are both high, and a strict-priority acceptance does not move the round. While `gnt_ready` is low and `q_ready` is unchanged, `gnt_qid` holds.
- R11: Configuration writes are ignored while `sched_en` is high. While `sched_en` is low, no grant is offered, writes are stored, and the round counter returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_en | input | 1 | Scheduler enable; configuration is locked while high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_qid | input | 4 | Queue index to write |
| cfg_code | input | 4 | Priority code (0..8 weight, 9 strict) |
| cfg_member | input | 1 | Queue belongs to the port |
| cfg_last | input | 1 | Queue is the last one of the port |
| q_ready | input | 16 | Per-queue non-empty flags |
| gnt_valid | output | 1 | A grant is offered |
| gnt_ready | input | 1 | Grant accepted by the consumer |
| gnt_qid | output | 4 | Granted queue index |
| has_static | output | 1 | At least one strict-priority member exists |
| static_last_qid | output | 4 | Highest strict-priority queue index |
| err_code | output | 1 | A member holds an out-of-range code |
| err_static | output | 1 | Strict-priority group is broken or does not start at queue 0 |

## Verification
Each code in turn is paired with a code-8 neighbour, and the sequence of eight grants that results spells out that code's mask bit by bit. This separates every mask from its neighbours and exposes a wrong mapping or round indexing. A three-queue mix runs for several passes of the round cycle to check the rotation pointer of each round. A wrong pointer or one shared pointer would shift the points where the sequence changes. Sparse ready patterns then force round skipping and idle cycles. Strict-priority mixes, broken groups, tail cut-off, stalled grants and writes made while enabled each test one rule that the weighted sequence alone cannot show.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
  localparam int ROUNDS  = 8;
  localparam int RND_W   = $clog2(ROUNDS);
  localparam int CODE_W  = 4;

  typedef logic [ROUNDS-1:0] rmask_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t STRICT_CODE = code_t'(9);

  // Evenly spread participation pattern per weight; strict and illegal codes run in every round.
  function automatic rmask_t code_to_mask(code_t c);
    case (c)
      code_t'(0): return 8'h00;
      code_t'(1): return 8'h01;
      code_t'(2): return 8'h11;
      code_t'(3): return 8'h49;
      code_t'(4): return 8'h55;
      code_t'(5): return 8'h57;
      code_t'(6): return 8'h77;
      code_t'(7): return 8'h7F;
      default:    return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/qs_cfg_table.sv
module qs_cfg_table
  import qsched_pkg::*;
#(
  parameter int NQ = 16,
  parameter int QW = $clog2(NQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sched_en,
  input  logic                      cfg_wr,
  input  logic [QW-1:0]             cfg_qid,
  input  code_t                     cfg_code,
  input  logic                      cfg_member,
  input  logic                      cfg_last,
  output logic [NQ-1:0][ROUNDS-1:0] rmask,
  output logic [NQ-1:0]             in_port,
  output logic [NQ-1:0]             is_static,
  output logic                      has_static,
  output logic [QW-1:0]             static_last,
  output logic                      err_code,
  output logic                      err_static
);
  logic [NQ-1:0][CODE_W-1:0] code_q;
  logic [NQ-1:0]             member_q;
  logic [NQ-1:0]             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      member_q <= '0;
      last_q   <= '0;
    end else if (cfg_wr && !sched_en && (int'(cfg_qid) < NQ)) begin
      code_q[cfg_qid]   <= cfg_code;
      member_q[cfg_qid] <= cfg_member;
      last_q[cfg_qid]   <= cfg_last;
    end
  end

  // Port membership: member and not beyond the first tail marker.
  always_comb begin
    logic cut;
    cut = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      in_port[i] = member_q[i] && !cut;
      if (last_q[i]) cut = 1'b1;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign rmask[g]     = code_to_mask(code_q[g]);
    assign is_static[g] = in_port[g] && (code_q[g] == STRICT_CODE);
  end

  always_comb begin
    err_code    = 1'b0;
    err_static  = 1'b0;
    static_last = '0;
    for (int i = 0; i < NQ; i++) begin
      if (in_port[i] && (code_q[i] > STRICT_CODE)) err_code = 1'b1;
      if (is_static[i]) static_last = QW'(i);
      if (i > 0 && is_static[i] && !is_static[i-1]) err_static = 1'b1;
    end
  end

  assign has_static = |is_static;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sched_en |=> $stable(code_q) && $stable(member_q) && $stable(last_q))
    else $error("config changed while enabled"); // R11
endmodule

// File: rtl/qs_rr_pick.sv
module qs_rr_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(start) + k) % N]) begin
        found = 1'b1;
        idx   = IW'((int'(start) + k) % N);
      end
    end
  end
endmodule

// File: rtl/wrr_qsched.sv
module wrr_qsched
  import qsched_pkg::*;
#(
  parameter int NQ = 16,
  parameter int QW = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_en,
  input  logic              cfg_wr,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_member,
  input  logic              cfg_last,
  input  logic [NQ-1:0]     q_ready,
  output logic              gnt_valid,
  input  logic              gnt_ready,
  output logic [QW-1:0]     gnt_qid,
  output logic              has_static,
  output logic [QW-1:0]     static_last_qid,
  output logic              err_code,
  output logic              err_static
);
  logic [NQ-1:0][ROUNDS-1:0] rmask;
  logic [NQ-1:0]             in_port, is_static;

  qs_cfg_table #(.NQ(NQ), .QW(QW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en),
    .cfg_wr(cfg_wr), .cfg_qid(cfg_qid), .cfg_code(cfg_code),
    .cfg_member(cfg_member), .cfg_last(cfg_last),
    .rmask(rmask), .in_port(in_port), .is_static(is_static),
    .has_static(has_static), .static_last(static_last_qid),
    .err_code(err_code), .err_static(err_static)
  );

  // Strict-priority path: fixed search from queue 0.
  logic [NQ-1:0] s_req;
  logic          s_found;
  logic [QW-1:0] s_idx;
  assign s_req = is_static & q_ready;

  qs_rr_pick #(.N(NQ), .IW(QW)) u_spick (
    .req(s_req), .start('0), .found(s_found), .idx(s_idx)
  );

  // Weighted path: eligibility per round.
  logic [NQ-1:0]             w_base;
  logic [ROUNDS-1:0][NQ-1:0] elig;
  logic [ROUNDS-1:0]         rnd_any;
  assign w_base = in_port & ~is_static & q_ready;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    for (genvar i = 0; i < NQ; i++) begin : g_q
      assign elig[r][i] = w_base[i] & rmask[i][r];
    end
    assign rnd_any[r] = |elig[r];
  end

  logic [RND_W-1:0]              round_q, eff_rnd;
  logic [ROUNDS-1:0][QW-1:0]     rr_last_q;
  logic                          any_rnd;

  always_comb begin
    any_rnd = 1'b0;
    eff_rnd = round_q;
    for (int k = 0; k < ROUNDS; k++) begin
      if (!any_rnd && rnd_any[(int'(round_q) + k) % ROUNDS]) begin
        any_rnd = 1'b1;
        eff_rnd = RND_W'((int'(round_q) + k) % ROUNDS);
      end
    end
  end

  logic [QW-1:0] w_start, w_idx;
  logic          w_found;
  assign w_start = (rr_last_q[eff_rnd] == QW'(NQ-1)) ? '0 : rr_last_q[eff_rnd] + QW'(1);

  qs_rr_pick #(.N(NQ), .IW(QW)) u_wpick (
    .req(elig[eff_rnd]), .start(w_start), .found(w_found), .idx(w_idx)
  );

  assign gnt_valid = sched_en && (s_found || w_found);
  assign gnt_qid   = s_found ? s_idx : w_idx;

  logic w_take;
  assign w_take = gnt_valid && gnt_ready && !s_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_q <= '0;
      for (int r = 0; r < ROUNDS; r++) rr_last_q[r] <= QW'(NQ-1);
    end else if (!sched_en) begin
      round_q <= '0;
    end else if (w_take) begin
      round_q            <= eff_rnd + RND_W'(1);
      rr_last_q[eff_rnd] <= w_idx;
    end
  end

  AST_GNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (q_ready[gnt_qid] && in_port[gnt_qid]))
    else $error("grant to a queue that is not ready or not in port"); // R9
  AST_STATIC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && (|s_req)) |-> is_static[gnt_qid])
    else $error("weighted queue beat a ready strict queue"); // R2
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_en |-> !gnt_valid)
    else $error("grant while disabled"); // R11
  AST_ROUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && !w_take) |=> $stable(round_q))
    else $error("round moved without weighted acceptance"); // R10
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt_valid && !gnt_ready && sched_en) && sched_en && $stable(q_ready)) |-> $stable(gnt_qid))
    else $error("grant changed while stalled"); // R10
endmodule

// File: tb/wrr_qsched_test.sv
`timescale 1ns/1ps
module wrr_qsched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sched_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_qid = '0;
  logic [3:0]  cfg_code = '0;
  logic        cfg_member = 1'b0;
  logic        cfg_last = 1'b0;
  logic [15:0] q_ready = '0;
  logic        gnt_ready = 1'b0;
  logic        gnt_valid;
  logic [3:0]  gnt_qid;
  logic        has_static;
  logic [3:0]  static_last_qid;
  logic        err_code, err_static;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  wrr_qsched uut (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en),
    .cfg_wr(cfg_wr), .cfg_qid(cfg_qid), .cfg_code(cfg_code),
    .cfg_member(cfg_member), .cfg_last(cfg_last),
    .q_ready(q_ready), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
    .gnt_qid(gnt_qid), .has_static(has_static),
    .static_last_qid(static_last_qid), .err_code(err_code), .err_static(err_static)
  );

  // {q_ready, expected valid, expected qid}; weights q0=8, q1=2, q2=1, q3=0 (tail)
  localparam logic [20:0] VEC [22] = '{
    {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0},
    {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0},
    {16'h000F, 1'b1, 4'd1}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0},
    {16'h000F, 1'b1, 4'd1}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0}, {16'h000F, 1'b1, 4'd0},
    {16'h000F, 1'b1, 4'd2}, {16'h0002, 1'b1, 4'd1}, {16'h0008, 1'b0, 4'd0}, {16'h0000, 1'b0, 4'd0},
    {16'h0004, 1'b1, 4'd2}, {16'h0001, 1'b1, 4'd0}
  };

  function automatic logic [7:0] ref_mask(int c);
    case (c)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h11;
      3: return 8'h49;  4: return 8'h55;  5: return 8'h57;
      6: return 8'h77;  7: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_gnt(string req, bit v, int q);
    check(req, "gnt_valid", int'(gnt_valid), int'(v));
    if (v) check(req, "gnt_qid", int'(gnt_qid), q);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sched_en = 1'b0; cfg_wr = 1'b0; q_ready = '0; gnt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(int q, int c, bit m, bit l);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_qid = 4'(q); cfg_code = 4'(c); cfg_member = m; cfg_last = l;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step(logic [15:0] r, bit acc);
    @(negedge clk);
    q_ready = r; gnt_ready = acc;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // Reset state
    do_reset();
    #1;
    check("R11", "gnt_valid after reset", int'(gnt_valid), 0);
    check("R8", "has_static after reset", int'(has_static), 0);
    check("R6", "err_code after reset", int'(err_code), 0);
    check("R7", "err_static after reset", int'(err_static), 0);

    // Table walk: rounds, rotation per round, skipping, idle
    cfg(0, 8, 1, 0); cfg(1, 2, 1, 0); cfg(2, 1, 1, 0); cfg(3, 0, 1, 1);
    @(negedge clk); sched_en = 1'b1;
    for (int i = 0; i < 22; i++) begin
      step(VEC[i][20:5], 1'b1);
      chk_gnt("R3 R4 R5", VEC[i][4], int'(VEC[i][3:0]));
    end

    // Every code against a code-8 neighbour: grant pattern spells the mask (R1, R6)
    for (int c = 0; c < 16; c++) begin
      do_reset();
      cfg(0, c, 1, 0); cfg(1, 8, 1, 1);
      #1;
      check("R6", "err_code", int'(err_code), (c >= 10) ? 1 : 0);
      check("R8", "has_static", int'(has_static), (c == 9) ? 1 : 0);
      @(negedge clk); sched_en = 1'b1;
      for (int r = 0; r < 8; r++) begin
        step(16'h0003, 1'b1);
        chk_gnt("R1", 1'b1, ref_mask(c)[r] ? 0 : 1);
      end
    end

    // Strict priority group
    do_reset();
    cfg(0, 9, 1, 0); cfg(1, 9, 1, 0); cfg(2, 4, 1, 0); cfg(3, 8, 1, 1);
    #1;
    check("R8", "has_static", int'(has_static), 1);
    check("R8", "static_last_qid", int'(static_last_qid), 1);
    check("R7", "err_static", int'(err_static), 0);
    @(negedge clk); sched_en = 1'b1;
    step(16'h000F, 1'b1); chk_gnt("R2", 1'b1, 0);
    step(16'h0006, 1'b1); chk_gnt("R2", 1'b1, 1);
    step(16'h000C, 1'b1); chk_gnt("R10", 1'b1, 2);   // round still 0
    step(16'h000C, 1'b1); chk_gnt("R3", 1'b1, 3);    // round 1: q2 off

    // Broken strict groups
    do_reset();
    cfg(0, 4, 1, 0); cfg(1, 9, 1, 1);
    #1;
    check("R7", "err_static not at base", int'(err_static), 1);
    check("R8", "static_last_qid", int'(static_last_qid), 1);
    cfg(0, 9, 1, 0); cfg(1, 3, 1, 0); cfg(2, 9, 1, 1);
    #1;
    check("R7", "err_static gap", int'(err_static), 1);
    cfg(2, 5, 1, 1);
    #1;
    check("R7", "err_static clean", int'(err_static), 0);
    check("R8", "static_last_qid", int'(static_last_qid), 0);

    // Membership and tail cut-off
    do_reset();
    cfg(0, 8, 1, 0); cfg(1, 8, 0, 0); cfg(2, 8, 1, 1); cfg(3, 8, 1, 0);
    @(negedge clk); sched_en = 1'b1;
    step(16'h000A, 1'b1); chk_gnt("R9", 1'b0, 0);
    step(16'h0004, 1'b1); chk_gnt("R9", 1'b1, 2);

    // Back-pressure
    do_reset();
    cfg(0, 1, 1, 0); cfg(1, 8, 1, 1);
    @(negedge clk); sched_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(16'h0003, 1'b0); chk_gnt("R10", 1'b1, 0);
    end
    step(16'h0003, 1'b1); chk_gnt("R10", 1'b1, 0);
    step(16'h0003, 1'b1); chk_gnt("R10", 1'b1, 1);
    step(16'h0000, 1'b0); chk_gnt("R4", 1'b0, 0);

    // Configuration lock and disable
    cfg(0, 0, 0, 0);
    step(16'h0001, 1'b1); chk_gnt("R11", 1'b1, 0);
    @(negedge clk); sched_en = 1'b0;
    step(16'h0001, 1'b1); chk_gnt("R11", 1'b0, 0);
    cfg(0, 0, 0, 0);
    @(negedge clk); sched_en = 1'b1;
    step(16'h0001, 1'b1); chk_gnt("R11", 1'b0, 0);
    step(16'h0002, 1'b1); chk_gnt("R11", 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule